// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the slave end of a half-duplex serial link through which a host reads and writes a small bank of 8-bit configuration registers. The link has three wires: a serial clock driven by the host, an active-low select, and one data line that both sides share. The block oversamples all three wires with its own system clock. It finds the serial clock edges by comparing consecutive synchronised samples, so the registers live in the system clock domain and no logic is clocked by the serial clock.

A transaction opens when select goes low. The host first shifts in a 16-bit instruction word. The word gives the direction, a burst length and a 13-bit start address. Data bytes follow. On a write the host keeps driving the line and each completed byte goes into the addressed register. On a read the block takes the line over on the serial clock falling edge that follows the last instruction bit. It then shifts register contents out, MSB first, and the host samples them on rising edges. After every data byte the address advances by one.

The controller is a five-state machine:
- `ST_IDLE`: select is high.
- `ST_INSTR`: shifting in the instruction.
- `ST_WDATA`: capturing write bytes.
- `ST_RDATA`: driving read bytes.
- `ST_DONE`: the burst is exhausted and the block waits for select to rise.

The transitions are:
- IDLE→INSTR when select is seen low.
- INSTR→WDATA or INSTR→RDATA on the 16th rising clock edge, chosen by the direction bit.
- WDATA→DONE and RDATA→DONE on the final rising edge of the last byte of a finite burst.
- Any state→IDLE whenever select is seen high. This is the abort path.

Top module: `spi3w_cfg_port`

## Requirements
- R1: After reset the data line is not driven (`spi_sdio_oe` = 0) and every implemented register reads 0x00.
- R2: The instruction word is sent MSB first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the burst code and bits 12:0 are the start address. On a write, each completed data byte, taken MSB first on rising serial clock edges, is stored in the addressed register.
- R3: On a read, `spi_sdio_oe` rises on the serial clock falling edge after the 16th instruction bit. Each register byte is presented MSB first, with every bit valid at the following rising edge.
- R4: The burst code selects how many data bytes take effect: 00 selects 1, 01 selects 2 and 10 selects 3. Write bytes beyond the burst are not stored. After the last read byte the data line is released while select is still low.
- R5: Burst code 11 keeps transferring bytes until select rises.
- R6: The address advances by one after each data byte and wraps from 0x1FFF to 0x0000.
- R7: The data line is never driven while select is high, during the instruction phase, or during a write.
- R8: If select rises before a data byte is complete, that partial byte is discarded and no register changes.
- R9: Addresses at or above `NUM_REGS` read as 0x00, and writes to them change nothing.
- R10: An aborted transaction leaves no state behind. The next transaction, opened by a new falling select, decodes a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host; idles low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sdio_in | input | 1 | Value seen on the shared data line |
| spi_sdio_out | output | 1 | Value the block puts on the data line |
| spi_sdio_oe | output | 1 | Output enable for the data line pad; 0 means high impedance |

## Verification
The bench sweeps every burst code over start addresses that cross the end of the implemented bank. It reads the whole bank back after each round, so a burst counter that is off by one shows up as a stored or missing byte in a neighbouring register. It opens a write one address below the 13-bit wrap point: an adder that does not wrap would lose the bytes meant for registers 0 and 1. It drops select part way through a data byte and also inside the instruction. A design that commits partial bytes would corrupt the register, and one that keeps bit counts across transactions would misdecode the next instruction. Finally, it checks that the line turns around exactly at the first read bit and is released after the last one. An early drive would collide with the host's last instruction bit, and a late release would collide with the next transaction.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
    localparam int ADDR_W  = 13;
    localparam int BYTE_W  = 8;
    localparam int INSTR_W = 16;
    localparam int CNT_W   = 4;
    localparam int LEN_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } spi_state_e;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic csn_in,
    input  logic sdi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic sdi_s
);
    // bit 2: serial clock, bit 1: select (idle high), bit 0: data
    localparam logic [2:0] IDLE_VAL = 3'b010;

    logic [2:0] pipe_q [STAGES];
    logic       sclk_prev_q;
    logic [2:0] last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= IDLE_VAL;
            sclk_prev_q <= 1'b0;
        end else begin
            pipe_q[0] <= {sclk_in, csn_in, sdi_in};
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            sclk_prev_q <= pipe_q[STAGES-1][2];
        end
    end

    assign last      = pipe_q[STAGES-1];
    assign sclk_rise = last[2] && !sclk_prev_q;
    assign sclk_fall = !last[2] && sclk_prev_q;
    assign cs_active = !last[1];
    assign sdi_s     = last[0];
endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && addr == ADDR_W'(g))
                regs_q[g] <= wdata;
        end
    end

    // addresses with no register fall through to zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) rdata = regs_q[i];
    end
endmodule

// File: rtl/spi3w_fsm.sv
module spi3w_fsm
    import spi3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              sdo,
    output logic              sdo_oe,
    output spi_state_e        state_q,
    output logic              read_q
);
    localparam int RW_POS = INSTR_W - 1;
    localparam int LEN_LO = INSTR_W - 1 - LEN_W;

    spi_state_e          next_state;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [INSTR_W-2:0]  in_shift_q;
    logic [INSTR_W-1:0]  instr_word;
    logic [LEN_W-1:0]    left_q;
    logic                stream_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   tx_q;
    logic                load_q;
    logic                sdo_q;
    logic                oe_q;
    logic                instr_end;
    logic                byte_end;
    logic                burst_over;

    assign instr_word = {in_shift_q, sdi};
    assign instr_end  = sclk_rise && bit_cnt_q == CNT_W'(INSTR_W - 1);
    assign byte_end   = sclk_rise && bit_cnt_q == CNT_W'(BYTE_W - 1);
    assign burst_over = !stream_q && left_q == '0;

    // next-state decision
    always_comb begin
        next_state = state_q;
        unique case (state_q)
            ST_IDLE:  next_state = ST_INSTR;
            ST_INSTR: if (instr_end)
                          next_state = instr_word[RW_POS] ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (byte_end && burst_over) next_state = ST_DONE;
            ST_RDATA: if (byte_end && burst_over) next_state = ST_DONE;
            ST_DONE:  next_state = ST_DONE;
            default:  next_state = ST_IDLE;
        endcase
        if (!cs_active) next_state = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= next_state;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            in_shift_q <= '0;
            left_q     <= '0;
            stream_q   <= 1'b0;
            addr_q     <= '0;
            tx_q       <= '0;
            load_q     <= 1'b0;
            sdo_q      <= 1'b0;
            oe_q       <= 1'b0;
            read_q     <= 1'b0;
        end else if (!cs_active) begin
            bit_cnt_q <= '0;
            load_q    <= 1'b0;
            oe_q      <= 1'b0;
            read_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_INSTR: begin
                    oe_q <= 1'b0;
                    if (sclk_rise) begin
                        in_shift_q <= instr_word[INSTR_W-2:0];
                        bit_cnt_q  <= bit_cnt_q + CNT_W'(1);
                    end
                    if (instr_end) begin
                        bit_cnt_q <= '0;
                        read_q    <= instr_word[RW_POS];
                        left_q    <= instr_word[RW_POS-1:LEN_LO];
                        stream_q  <= &instr_word[RW_POS-1:LEN_LO];
                        addr_q    <= instr_word[ADDR_W-1:0];
                        load_q    <= instr_word[RW_POS];
                    end
                end
                ST_WDATA, ST_RDATA: begin
                    if (sclk_rise) begin
                        in_shift_q <= instr_word[INSTR_W-2:0];
                        bit_cnt_q  <= bit_cnt_q + CNT_W'(1);
                    end
                    if (byte_end) begin
                        bit_cnt_q <= '0;
                        addr_q    <= addr_q + ADDR_W'(1);
                        if (!stream_q) left_q <= left_q - LEN_W'(1);
                        load_q    <= (state_q == ST_RDATA);
                    end
                    if (state_q == ST_RDATA) begin
                        if (load_q) begin
                            tx_q   <= rd_data;
                            load_q <= 1'b0;
                        end else if (sclk_fall) begin
                            oe_q  <= 1'b1;
                            sdo_q <= tx_q[BYTE_W-1];
                            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end else begin
                        oe_q <= 1'b0;
                    end
                end
                default: begin
                    oe_q   <= 1'b0;
                    load_q <= 1'b0;
                end
            endcase
        end
    end

    assign reg_we    = (state_q == ST_WDATA) && byte_end && cs_active;
    assign reg_addr  = addr_q;
    assign reg_wdata = instr_word[BYTE_W-1:0];
    assign sdo       = sdo_q;
    assign sdo_oe    = oe_q;
endmodule

// File: rtl/spi3w_cfg_port.sv
module spi3w_cfg_port
    import spi3w_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_sdio_in,
    output logic spi_sdio_out,
    output logic spi_sdio_oe
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_active;
    logic              sdi_s;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [BYTE_W-1:0] reg_wdata;
    logic [BYTE_W-1:0] reg_rdata;
    spi_state_e        fsm_state;
    logic              read_q;

    spi3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .csn_in    (spi_cs_n),
        .sdi_in    (spi_sdio_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .sdi_s     (sdi_s)
    );

    spi3w_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (sdi_s),
        .rd_data   (reg_rdata),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sdo       (spi_sdio_out),
        .sdo_oe    (spi_sdio_oe),
        .state_q   (fsm_state),
        .read_q    (read_q)
    );

    spi3w_regbank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (BYTE_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/spi3w_cfg_port_chk.sv
module spi3w_cfg_port_chk
    import spi3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_active,
    input logic              sclk_fall,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              sdio_oe,
    input logic              read_q,
    input spi_state_e        fsm_state
);
    assert_no_drive_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && $past(!cs_active)) |-> !sdio_oe);

    assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> read_q);

    assert_turnaround_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sclk_fall));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we) |-> reg_addr == ADDR_W'($past(reg_addr) + ADDR_W'(1)));

    assert_write_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(cs_active));

    assert_write_not_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!read_q && fsm_state == ST_WDATA));
endmodule

bind spi3w_cfg_port spi3w_cfg_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .sclk_fall (sclk_fall),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .sdio_oe   (spi_sdio_oe),
    .read_q    (read_q),
    .fsm_state (fsm_state)
);

// File: tb/test_spi3w_cfg_port.sv
`timescale 1ns/1ps
module test_spi3w_cfg_port;
    localparam int NREG = 8;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic host_val = 1'b0;
    logic host_drive = 1'b0;
    logic sdio_out;
    logic sdio_oe;
    logic sdio_bus;
    logic contention;
    int   n_checks = 0;
    int   n_fail = 0;
    int   cycles = 0;
    logic [7:0] tx_buf [0:15];
    logic [7:0] rx_buf [0:15];
    logic [7:0] model [0:NREG-1];

    always #4 clk = ~clk;

    assign sdio_bus = sdio_oe ? sdio_out : host_val;

    spi3w_cfg_port #(.NUM_REGS(NREG)) i_spi3w_cfg_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (sclk),
        .spi_cs_n     (cs_n),
        .spi_sdio_in  (sdio_bus),
        .spi_sdio_out (sdio_out),
        .spi_sdio_oe  (sdio_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (sdio_oe && host_drive) contention <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    // stop_bits < 0: full transfer of nbytes; otherwise select rises after that many bits
    task automatic xfer(input logic rw, input logic [1:0] wl, input logic [12:0] a,
                        input int nbytes, input int stop_bits, input bit chk_release);
        logic [15:0] iw;
        int total;
        iw = {rw, wl, a};
        total = (stop_bits >= 0) ? stop_bits : 16 + nbytes * 8;
        contention = 1'b0;
        cs_n = 1'b0;
        half();
        for (int b = 0; b < total; b++) begin
            if (b < 16) begin
                host_drive = 1'b1; host_val = iw[15-b];
            end else if (!rw) begin
                host_drive = 1'b1; host_val = tx_buf[(b-16)/8][7-((b-16)%8)];
            end else begin
                host_drive = 1'b0;
            end
            half();
            if (rw && b >= 16) begin
                if (b == 16) chk(sdio_oe === 1'b1, "R3 line driven at first read bit", int'(sdio_oe), 1);
                rx_buf[(b-16)/8][7-((b-16)%8)] = sdio_bus;
            end
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        host_drive = 1'b0;
        if (chk_release) begin
            half(); half();
            chk(sdio_oe === 1'b0, "R4 released after burst", int'(sdio_oe), 0);
        end
        cs_n = 1'b1;
        half(); half();
        chk(sdio_oe === 1'b0, "R7 released when deselected", int'(sdio_oe), 0);
        chk(contention === 1'b0, "R7 no drive in instruction or write", int'(contention), 0);
    endtask

    function automatic logic [7:0] exp_at(input int a);
        return (a < NREG) ? model[a] : 8'h00;
    endfunction

    task automatic model_write(input int start, input int n);
        for (int k = 0; k < n; k++) begin
            int a;
            a = (start + k) % 8192;
            if (a < NREG) model[a] = tx_buf[k];
        end
    endtask

    task automatic read_bank(input string tag);
        xfer(1'b1, 2'b11, 13'd0, 10, -1, 1'b0);
        for (int k = 0; k < 10; k++)
            chk(rx_buf[k] === exp_at(k), tag, int'(rx_buf[k]), int'(exp_at(k)));
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sdio_oe === 1'b0, "R1 reset leaves line undriven", int'(sdio_oe), 0);
        read_bank("R1 reset contents / R9 unimplemented read");

        // R2 R4 R5 R10: every burst code over starts 0..9
        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 10; s++) begin
                int n;
                n = (w == 3) ? 4 : w + 1;
                for (int k = 0; k < n; k++) tx_buf[k] = 8'((s * 29 + w * 71 + k * 13 + 1) & 255);
                xfer(1'b0, 2'(w), 13'(s), n, -1, 1'b0);
                model_write(s, n);
            end
            read_bank((w == 3) ? "R5 streaming write sweep" : "R2/R4 burst write sweep");
        end

        // R4: burst code 00 but three bytes sent; only the first is stored
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h5A; tx_buf[2] = 8'hC3;
        xfer(1'b0, 2'b00, 13'd2, 3, -1, 1'b0);
        model_write(2, 1);
        xfer(1'b1, 2'b10, 13'd2, 3, -1, 1'b1);
        for (int k = 0; k < 3; k++)
            chk(rx_buf[k] === exp_at(2 + k), "R4 extra write bytes dropped", int'(rx_buf[k]), int'(exp_at(2 + k)));
        xfer(1'b1, 2'b00, 13'd2, 1, -1, 1'b1);
        chk(rx_buf[0] === exp_at(2), "R4 single read", int'(rx_buf[0]), int'(exp_at(2)));
        xfer(1'b1, 2'b01, 13'd6, 2, -1, 1'b1);
        chk(rx_buf[0] === exp_at(6), "R4 two-byte read first", int'(rx_buf[0]), int'(exp_at(6)));
        chk(rx_buf[1] === exp_at(7), "R4 two-byte read second", int'(rx_buf[1]), int'(exp_at(7)));

        // R6: wrap from 0x1FFF to 0
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        xfer(1'b0, 2'b10, 13'h1FFF, 3, -1, 1'b0);
        model_write(8191, 3);
        read_bank("R6 address wrap");

        // R9: unimplemented addresses
        tx_buf[0] = 8'hFF; tx_buf[1] = 8'hEE;
        xfer(1'b0, 2'b01, 13'd100, 2, -1, 1'b0);
        xfer(1'b1, 2'b01, 13'd100, 2, -1, 1'b1);
        chk(rx_buf[0] === 8'h00, "R9 unimplemented read 100", int'(rx_buf[0]), 0);
        chk(rx_buf[1] === 8'h00, "R9 unimplemented read 101", int'(rx_buf[1]), 0);

        // R8: select rises after 5 data bits
        tx_buf[0] = 8'h00;
        xfer(1'b0, 2'b00, 13'd5, 1, 21, 1'b0);
        // R8: abort in second byte of a burst; first byte stays
        tx_buf[0] = 8'h77; tx_buf[1] = 8'h88;
        xfer(1'b0, 2'b01, 13'd3, 2, 16 + 8 + 7, 1'b0);
        model_write(3, 1);
        read_bank("R8 partial byte discarded");

        // R10: abort inside the instruction, then a clean transaction
        xfer(1'b1, 2'b11, 13'd0, 1, 10, 1'b0);
        tx_buf[0] = 8'h3C;
        xfer(1'b0, 2'b00, 13'd4, 1, -1, 1'b0);
        model_write(4, 1);
        xfer(1'b1, 2'b00, 13'd4, 1, -1, 1'b1);
        chk(rx_buf[0] === 8'h3C, "R10 fresh decode after abort", int'(rx_buf[0]), 8'h3C);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles >= 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule